// File: doc/BRIEF.md
# Real-Time Counter Control and Prescaler Front End

This block holds the control byte for a low-speed real-time counter that runs on its own clock. The system bus writes and reads the byte in the system clock domain. Each accepted write is handed across to the counter clock domain with a toggle handshake. A busy flag stays high from the accepting edge until the counter domain has taken the value and its acknowledge has come back through a two-flop synchronizer. While the flag is high, further writes are dropped.

In the counter domain, the effective control byte drives a free-running prescaler. A four-bit select field picks a division ratio of 2^N. The prescaler produces a single-cycle count-enable tick. The tick is gated by the enable bit and by the standby-run bit, which decides whether the counter keeps going while the chip is in standby. The correction-enable bit is not interpreted here. It is only carried to an output for the correction logic downstream.

Control byte layout: bit 0 enable, bit 1 reserved (always 0), bit 2 correction enable, bits 6:3 prescaler select N, bit 7 run-in-standby.

Top module: `rtcc_ctrl`

## Requirements
- R1: After reset, rd_data_o, eff_ctrl_o, busy_o, corr_en_o and tick_o are all 0.
- R2: A write on a system clock edge with busy_o low is accepted, and from that edge on rd_data_o returns the written byte with bit 1 forced to 0.
- R3: busy_o is high right after the system edge that accepts a write. It returns low within 40 system clock cycles once the counter domain has acknowledged the write.
- R4: A write presented while busy_o is high is ignored, and rd_data_o and the value that later reaches eff_ctrl_o are unchanged by it.
- R5: eff_ctrl_o keeps its old value after the first rising counter-clock edge that follows the accepting system edge, and shows the new value after the second one.
- R6: Bit 1 of both rd_data_o and eff_ctrl_o is always 0.
- R7: With enable (bit 0) set and select field N (bits 6:3), tick_o first goes high in the (2^N)th counter cycle after the enable takes effect. From then on it pulses once every 2^N counter cycles, for every N from 0 to 15.
- R8: With N = 0, tick_o is high in every counter cycle while counting is allowed.
- R9: With enable at 0, tick_o stays low and the prescaler is held at zero.
- R10: While standby_i is high and bit 7 is 0, tick_o is low and the prescaler holds its count. With bit 7 set, standby_i has no effect.
- R11: corr_en_o follows bit 2 of the effective control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | System bus clock |
| cnt_clk_i | input | 1 | Counter clock, unrelated to the system clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en_i | input | 1 | Write strobe for the control byte (system domain) |
| wr_data_i | input | 8 | Control byte to write |
| rd_data_o | output | 8 | Last accepted control byte |
| busy_o | output | 1 | High while an update is crossing to the counter domain |
| standby_i | input | 1 | Standby sleep indication (counter domain) |
| eff_ctrl_o | output | 8 | Control byte currently in effect in the counter domain |
| corr_en_o | output | 1 | Correction enable, as in effect |
| tick_o | output | 1 | Count-enable pulse from the prescaler |

## Verification
The bench builds the block with its default four-bit select field, which gives a fifteen-bit prescaler. It drives a counter clock of about 7.13 ns against the 20 ns system clock. The two clock edges never coincide, so the two-edge update latency can be checked exactly. The fast counter clock also lets the full 32768-cycle period of the largest division be timed inside the run. At that setting every select value is exercised, both the first tick after enable and the spacing between ticks.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
  localparam int CTRL_W   = 8;
  localparam int BIT_EN   = 0;
  localparam int BIT_RSVD = 1;
  localparam int BIT_CORR = 2;
  localparam int PSEL_LSB = 3;
  localparam int PSEL_W   = 4;
  localparam int BIT_STBY = 7;
  typedef logic [CTRL_W-1:0] ctrl_t;
  localparam ctrl_t RSVD_CLEAR = ~(ctrl_t'(1) << BIT_RSVD);
endpackage

// File: rtl/rtcc_rst_sync.sv
module rtcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rtcc_bus_side.sv
module rtcc_bus_side
  import rtcc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en_i,
  input  ctrl_t wr_data_i,
  input  logic  ack_tog_i,
  output ctrl_t shadow_o,
  output logic  req_tog_o,
  output logic  busy_o
);
  ctrl_t shadow_q, shadow_d;
  logic  req_q, req_d;
  logic  ack_s1_q, ack_s2_q;
  logic  accept;

  assign busy_o = req_q ^ ack_s2_q;
  assign accept = wr_en_i & ~busy_o;

  always_comb begin
    shadow_d = shadow_q;
    req_d    = req_q;
    if (accept) begin
      shadow_d = wr_data_i & RSVD_CLEAR;
      req_d    = ~req_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      req_q    <= 1'b0;
      ack_s1_q <= 1'b0;
      ack_s2_q <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      req_q    <= req_d;
      ack_s1_q <= ack_tog_i;
      ack_s2_q <= ack_s1_q;
    end
  end

  assign shadow_o  = shadow_q;
  assign req_tog_o = req_q;

  p_busy_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !busy_o) |=> busy_o);
  p_ignore_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && busy_o) |=> ($stable(shadow_q) && $stable(req_q)));
endmodule

// File: rtl/rtcc_cnt_side.sv
module rtcc_cnt_side
  import rtcc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_tog_i,
  input  ctrl_t hold_i,
  output ctrl_t eff_o,
  output logic  ack_tog_o
);
  logic  req_s1_q, req_s2_q;
  logic  seen_q, seen_d;
  ctrl_t active_q, active_d;
  logic  pending;

  assign pending = req_s2_q ^ seen_q;

  always_comb begin
    active_d = active_q;
    seen_d   = req_s2_q;
    if (pending) active_d = hold_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1_q <= 1'b0;
      req_s2_q <= 1'b0;
      seen_q   <= 1'b0;
      active_q <= '0;
    end else begin
      req_s1_q <= req_tog_i;
      req_s2_q <= req_s1_q;
      seen_q   <= seen_d;
      active_q <= active_d;
    end
  end

  // the new byte is visible as soon as the toggle leaves the second flop
  assign eff_o     = pending ? hold_i : active_q;
  assign ack_tog_o = seen_q;

  p_eff_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !$past(pending)) |-> $stable(eff_o));
  p_ack_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> (ack_tog_o == $past(req_s2_q)));
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_o[BIT_RSVD]);
endmodule

// File: rtl/rtcc_prescaler.sv
module rtcc_prescaler #(
  parameter int PSEL_W  = 4,
  localparam int PRESC_W = (1 << PSEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              run_stby_i,
  input  logic              standby_i,
  input  logic [PSEL_W-1:0] sel_i,
  output logic              tick_o
);
  logic [PRESC_W-1:0] cnt_q, cnt_d;
  logic [PRESC_W-1:0] mask;
  logic               run;

  assign run = en_i & (run_stby_i | ~standby_i);

  always_comb begin
    for (int i = 0; i < PRESC_W; i++) mask[i] = (i < int'(sel_i));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)    cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run & (&(cnt_q | ~mask));

  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && standby_i && !run_stby_i) |=> $stable(cnt_q));
  p_no_tick_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_i && !run_stby_i) |-> !tick_o);
  p_div1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel_i == '0) |-> tick_o);
endmodule

// File: rtl/rtcc_ctrl.sv
module rtcc_ctrl
  import rtcc_pkg::*;
#(
  parameter int SEL_W = PSEL_W
) (
  input  logic        sys_clk_i,
  input  logic        cnt_clk_i,
  input  logic        rst_n_i,
  input  logic        wr_en_i,
  input  logic [7:0]  wr_data_i,
  output logic [7:0]  rd_data_o,
  output logic        busy_o,
  input  logic        standby_i,
  output logic [7:0]  eff_ctrl_o,
  output logic        corr_en_o,
  output logic        tick_o
);
  logic  sys_rst_n, cnt_rst_n;
  logic  req_tog, ack_tog;
  ctrl_t shadow, eff;

  rtcc_rst_sync #(.STAGES(2)) u_sys_rst (
    .clk(sys_clk_i), .rst_n_i(rst_n_i), .rst_n_o(sys_rst_n));
  rtcc_rst_sync #(.STAGES(2)) u_cnt_rst (
    .clk(cnt_clk_i), .rst_n_i(rst_n_i), .rst_n_o(cnt_rst_n));

  rtcc_bus_side u_bus (
    .clk(sys_clk_i), .rst_n(sys_rst_n), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .ack_tog_i(ack_tog), .shadow_o(shadow),
    .req_tog_o(req_tog), .busy_o(busy_o));

  rtcc_cnt_side u_cnt (
    .clk(cnt_clk_i), .rst_n(cnt_rst_n), .req_tog_i(req_tog),
    .hold_i(shadow), .eff_o(eff), .ack_tog_o(ack_tog));

  rtcc_prescaler #(.PSEL_W(SEL_W)) u_presc (
    .clk(cnt_clk_i), .rst_n(cnt_rst_n), .en_i(eff[BIT_EN]),
    .run_stby_i(eff[BIT_STBY]), .standby_i(standby_i),
    .sel_i(eff[PSEL_LSB +: SEL_W]), .tick_o(tick_o));

  assign rd_data_o  = shadow;
  assign eff_ctrl_o = eff;
  assign corr_en_o  = eff[BIT_CORR];
endmodule

// File: tb/tb_rtcc_ctrl.sv
`timescale 1ns/1ps
module tb_rtcc_ctrl;
  logic sys_clk = 1'b0, cnt_clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, standby = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, eff_ctrl;
  logic busy, corr_en, tick;
  int checks = 0, fails = 0;
  logic [7:0] exp_reg = '0;

  rtcc_ctrl dut (
    .sys_clk_i(sys_clk), .cnt_clk_i(cnt_clk), .rst_n_i(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .busy_o(busy), .standby_i(standby), .eff_ctrl_o(eff_ctrl),
    .corr_en_o(corr_en), .tick_o(tick));

  always #10 sys_clk = ~sys_clk;
  initial begin
    #1.234;
    forever #3.565 cnt_clk = ~cnt_clk;
  end

  function automatic logic [7:0] stored(input logic [7:0] v);
    return v & 8'hFD;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge sys_clk);
    while (busy && n < 40) begin @(negedge sys_clk); n++; end
    chk("R3 busy clears", {31'd0, busy}, 32'd0);
    repeat (2) @(posedge cnt_clk);
    #1;
  endtask

  // accepted write with latency checks; returns about 1 ns after the second counter edge
  task automatic wr(input logic [7:0] v);
    logic [7:0] old = exp_reg;
    @(negedge sys_clk);
    wr_en = 1'b1; wr_data = v;
    @(posedge sys_clk);
    @(posedge cnt_clk); #1;
    chk("R5 old value after first edge", eff_ctrl, old);
    @(posedge cnt_clk); #1;
    exp_reg = stored(v);
    chk("R5 new value after second edge", eff_ctrl, exp_reg);
    chk("R6 eff reserved bit", {31'd0, eff_ctrl[1]}, 32'd0);
    chk("R11 corr follows", {31'd0, corr_en}, {31'd0, exp_reg[2]});
    chk("R3 busy after accept", {31'd0, busy}, 32'd1);
    chk("R2 readback", rd_data, exp_reg);
    wr_en = 1'b0;
  endtask

  task automatic measure_ticks(input int n);
    int idx = 0;
    int lim = (1 << n) + 4;
    while (!tick && idx < lim) begin @(posedge cnt_clk); #1; idx++; end
    chk($sformatf("R7 first tick N=%0d", n), idx, (1 << n) - 1);
    @(posedge cnt_clk); #1; idx = 1;
    while (!tick && idx < lim) begin @(posedge cnt_clk); #1; idx++; end
    chk($sformatf("R7 period N=%0d", n), idx, 1 << n);
  endtask

  initial begin : watchdog
    #5ms;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int ones;
    void'($urandom(32'd1357));
    #95 rst_n = 1'b1;
    repeat (4) @(negedge sys_clk);
    #1;
    chk("R1 rd_data", rd_data, 0);
    chk("R1 eff_ctrl", eff_ctrl, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 corr_en", {31'd0, corr_en}, 0);
    chk("R1 tick", {31'd0, tick}, 0);

    // directed: reserved bit and correction bit
    wr(8'h06); wait_idle();
    chk("R6 rd reserved bit", {31'd0, rd_data[1]}, 0);
    chk("R9 no tick when disabled", {31'd0, tick}, 0);

    // R4: write during busy dropped
    wr(8'h01);
    @(negedge sys_clk);
    wr_en = 1'b1; wr_data = 8'hF9;
    @(negedge sys_clk); wr_en = 1'b0;
    chk("R4 rd unchanged", rd_data, 8'h01);
    wait_idle();
    repeat (4) @(posedge cnt_clk); #1;
    chk("R4 eff unchanged", eff_ctrl, 8'h01);

    // R8: divide by one, every cycle
    ones = 0;
    for (int i = 0; i < 10; i++) begin @(posedge cnt_clk); #1; ones += tick; end
    chk("R8 tick every cycle", ones, 10);

    // R10: standby halts when bit 7 clear
    @(negedge cnt_clk); standby = 1'b1;
    ones = 0;
    for (int i = 0; i < 10; i++) begin @(posedge cnt_clk); #1; ones += tick; end
    chk("R10 halted in standby", ones, 0);
    @(negedge cnt_clk); standby = 1'b0;
    wr(8'h81); wait_idle();
    @(negedge cnt_clk); standby = 1'b1;
    ones = 0;
    for (int i = 0; i < 10; i++) begin @(posedge cnt_clk); #1; ones += tick; end
    chk("R10 runs in standby with bit 7", ones, 10);
    @(negedge cnt_clk); standby = 1'b0;

    // R10 count hold: N=3, halt mid-period
    wr(8'h00); wait_idle();
    wr(8'h19);
    begin
      int idx = 0;
      while (!tick && idx < 20) begin @(posedge cnt_clk); #1; idx++; end
      chk("R7 first tick N=3 before halt", idx, 7);
      @(negedge cnt_clk);
      repeat (2) @(posedge cnt_clk);
      @(negedge cnt_clk); standby = 1'b1;
      repeat (9) @(negedge cnt_clk);
      standby = 1'b0;
      idx = 3;
      @(posedge cnt_clk); #1;
      while (!tick && idx < 20) begin @(posedge cnt_clk); #1; idx++; end
      chk("R10 count held across standby", idx, 8);
    end
    wait_idle();

    // R7: all sixteen select values
    for (int n = 0; n < 16; n++) begin
      wr(8'h00); wait_idle();
      wr(8'((n << 3) | 1));
      measure_ticks(n);
      wait_idle();
    end

    // R9: disable clears prescaler
    wr(8'h00); wait_idle();
    ones = 0;
    for (int i = 0; i < 8; i++) begin @(posedge cnt_clk); #1; ones += tick; end
    chk("R9 no tick after disable", ones, 0);

    // random writes, some landing while busy
    for (int k = 0; k < 40; k++) begin
      repeat ($urandom_range(0, 3)) @(negedge sys_clk);
      @(negedge sys_clk);
      v = 8'($urandom);
      wr_en = 1'b1; wr_data = v;
      if (!busy) exp_reg = stored(v);
      @(negedge sys_clk); wr_en = 1'b0;
      chk("R2/R4 random readback", rd_data, exp_reg);
    end
    wait_idle();
    repeat (3) @(posedge cnt_clk); #1;
    chk("R5 random final effect", eff_ctrl, exp_reg);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule